// File: doc/BRIEF.md
# Chained Two-Stage Free-Running Counter

This block joins two identical up-counters into one counter twice their width. The lower stage advances on ticks from a selectable power-of-two prescaler of the block clock. A waveform generator on the lower stage goes high when the lower stage wraps to zero and low when it reaches half of its range. That gives one rising edge per full lower-stage cycle. The upper stage has no direct carry from the lower stage. It is clocked through a source selector. The selector picks the lower-stage waveform, an outside input, or nothing. A synchronous rising-edge detector in the block clock domain feeds the upper stage.

A single sync strobe clears the prescaler, both stages and the waveform together, so the pair restarts from zero. Between a lower-stage wrap and the upper-stage increment, the raw value is out of step for one clock. A coherent read port therefore samples the upper half, then the lower half, then the upper half again. It repeats the sequence until the two upper samples agree, and returns a value the counter really held.

Top module: `chained_counter`

## Requirements
- R1: While rst_n is low at a clock edge, count_o becomes 0, lo_wave_o becomes 0 and rd_valid_o becomes 0.
- R2: A clock edge with sync_i high clears both halves of count_o, the prescaler phase and lo_wave_o. Counting then resumes from zero.
- R3: With psc_sel_i = s, the lower half advances by one every 2^(1+2s) clocks after a sync while lo_en_i is high. While lo_en_i is low, the lower half holds.
- R4: lo_wave_o rises on the edge where the lower half wraps from all ones to 0. It falls on the edge where the lower half reaches 2^(W-1), where W is the stage width. It stays low after a sync until the first wrap.
- R5: With route_i = 2'b01, the upper half increments on the clock edge after each rise of lo_wave_o. With route_i = 2'b00 or 2'b11, the upper half holds.
- R6: With route_i = 2'b10, the upper half increments on the first clock edge that sees xclk_i high after it was low.
- R7: While hi_en_i is low, the upper half holds whatever the selected source does.
- R8: count_o is {upper, lower}. After a sync at edge 0 with both enables high and route 2'b01, edge n shows lower = floor(n/D) mod 2^W. It shows upper = floor(floor((n-1)/D)/2^W) mod 2^W, where D is the prescale divisor.
- R9: A read request taken in idle captures the upper half, then the lower half on the next edge. The upper half is compared on the edge after that. On a match, rd_valid_o pulses for one clock with rd_data_o equal to the count held at the lower-half sample, three clocks after the request. On a mismatch the sequence restarts from the new upper sample, which adds two clocks.
- R10: rd_req_i is ignored while a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Restart both stages and the prescaler from zero |
| psc_sel_i | input | SEL_W | Prescale select, divisor 2^(1+PSC_STEP*sel) |
| lo_en_i | input | 1 | Lower stage count enable |
| hi_en_i | input | 1 | Upper stage count enable |
| route_i | input | 2 | Upper clock source: 01 lower waveform, 10 xclk_i, else none |
| xclk_i | input | 1 | Outside clock source, synchronous to clk |
| rd_req_i | input | 1 | Start a coherent read |
| count_o | output | 2*CH_W | Raw combined count {upper, lower} |
| lo_wave_o | output | 1 | Lower stage square wave |
| rd_valid_o | output | 1 | One-clock pulse: rd_data_o holds a coherent value |
| rd_data_o | output | 2*CH_W | Coherent read result |

## Verification
A wrong prescaler phase or lower-stage value shows on count_o on the very next tick, so a per-clock comparison against the closed-form count catches it within one divisor period. A wrong waveform state or a lost edge in the selector shows only at the next wrap. The upper half is then short by one, or one clock late, and stays wrong from then on, so sweeps run through several full wraps at every divisor. A broken read sequencer shows as a torn value, or as a wrong latency on reads placed across a wrap.

// File: rtl/cc_pkg.sv
// Shared types for the chained counter.
package cc_pkg;
    // Upper-stage clock source selection.
    typedef enum logic [1:0] {
        RT_OFF   = 2'b00,
        RT_CHAIN = 2'b01,
        RT_EXT   = 2'b10,
        RT_OFF2  = 2'b11
    } route_t;

    // Coherent read sequencer states.
    typedef enum logic [1:0] {
        RD_IDLE = 2'b00,
        RD_LO   = 2'b01,
        RD_CHK  = 2'b10
    } rd_state_t;
endpackage

// File: rtl/cc_prescaler.sv
// Power-of-two prescaler. Emits a one-clock tick every 2^(1+STEP*sel) clocks.
// Assumes sel is stable while counting; a larger-than-limit phase wraps at once.
module cc_prescaler #(
    parameter int SEL_W = 2,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int PSC_CW = 1 + STEP * ((1 << SEL_W) - 1);

    logic [PSC_CW-1:0] phase_q;
    logic [PSC_CW-1:0] limit;
    int unsigned       shamt;

    // Terminal phase for the selected divisor.
    always_comb begin
        shamt  = PSC_CW - 1 - STEP * int'(sel_i);
        limit  = {PSC_CW{1'b1}} >> shamt;
        tick_o = (phase_q >= limit);
    end

    // Phase counter, cleared by sync.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  phase_q <= '0;
        else if (tick_o)      phase_q <= '0;
        else                  phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/cc_channel.sv
// One up-counting stage. Clear has priority over increment; wraps naturally.
module cc_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    // Stage count register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_o <= '0;
        else if (inc_i)      cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/cc_wavegen.sv
// Square wave from the lower stage: high from the wrap to zero, low from half range.
// Assumes it sees the same tick and current count as the stage it watches.
module cc_wavegen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic [W-1:0] cnt_i,
    output logic         wave_o
);
    localparam logic [W-1:0] TOP     = {W{1'b1}};
    localparam logic [W-1:0] PRE_MID = (W'(1) << (W - 1)) - W'(1);

    // Set on the step into zero, clear on the step into half range.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) wave_o <= 1'b0;
        else if (tick_i) begin
            if (cnt_i == TOP)          wave_o <= 1'b1;
            else if (cnt_i == PRE_MID) wave_o <= 1'b0;
        end
    end
endmodule

// File: rtl/cc_route.sv
// Upper-stage source selector and synchronous rising-edge detector.
// Assumes xclk_i is already synchronous to clk.
module cc_route
    import cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] route_i,
    input  logic       wave_i,
    input  logic       xclk_i,
    output logic       rise_o
);
    logic   src;
    logic   src_q;
    route_t rt;

    // Pick the source named by the routing field.
    always_comb begin
        rt = route_t'(route_i);
        case (rt)
            RT_CHAIN: src = wave_i;
            RT_EXT:   src = xclk_i;
            default:  src = 1'b0;
        endcase
        rise_o = src & ~src_q;
    end

    // Previous source level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end
endmodule

// File: rtl/cc_reader.sv
// Tear-free read: upper, lower, upper again; retry while the two upper samples differ.
// Requests arriving while busy are dropped.
module cc_reader
    import cc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic [W-1:0]   hi_i,
    input  logic [W-1:0]   lo_i,
    output logic           valid_o,
    output logic [2*W-1:0] data_o
);
    rd_state_t    st_q;
    logic [W-1:0] hi_s;
    logic [W-1:0] lo_s;

    // Sampling sequence and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RD_IDLE;
            hi_s    <= '0;
            lo_s    <= '0;
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            case (st_q)
                RD_IDLE: if (req_i) begin
                    hi_s <= hi_i;
                    st_q <= RD_LO;
                end
                RD_LO: begin
                    lo_s <= lo_i;
                    st_q <= RD_CHK;
                end
                RD_CHK: if (hi_i == hi_s) begin
                    data_o  <= {hi_s, lo_s};
                    valid_o <= 1'b1;
                    st_q    <= RD_IDLE;
                end else begin
                    hi_s <= hi_i;
                    st_q <= RD_LO;
                end
                default: st_q <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chained_counter.sv
// Two stages chained through a waveform edge into one double-width counter.
// Assumes all inputs synchronous to clk; sync restarts everything from zero.
module chained_counter #(
    parameter int CH_W     = 16,
    parameter int SEL_W    = 2,
    parameter int PSC_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [SEL_W-1:0]  psc_sel_i,
    input  logic              lo_en_i,
    input  logic              hi_en_i,
    input  logic [1:0]        route_i,
    input  logic              xclk_i,
    input  logic              rd_req_i,
    output logic [2*CH_W-1:0] count_o,
    output logic              lo_wave_o,
    output logic              rd_valid_o,
    output logic [2*CH_W-1:0] rd_data_o
);
    localparam int NCH = 2;

    logic            psc_tick;
    logic            rise;
    logic            ch_inc [NCH];
    logic [CH_W-1:0] ch_cnt [NCH];

    cc_prescaler #(.SEL_W(SEL_W), .STEP(PSC_STEP)) u_psc (
        .clk(clk), .rst_n(rst_n), .clr_i(sync_i), .sel_i(psc_sel_i), .tick_o(psc_tick)
    );

    // Stage increments: lower from the prescaler, upper from the routed edge.
    assign ch_inc[0] = psc_tick & lo_en_i;
    assign ch_inc[1] = rise & hi_en_i;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cc_channel #(.W(CH_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .clr_i(sync_i), .inc_i(ch_inc[c]), .cnt_o(ch_cnt[c])
        );
    end

    cc_wavegen #(.W(CH_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .clr_i(sync_i), .tick_i(ch_inc[0]),
        .cnt_i(ch_cnt[0]), .wave_o(lo_wave_o)
    );

    cc_route u_route (
        .clk(clk), .rst_n(rst_n), .route_i(route_i), .wave_i(lo_wave_o),
        .xclk_i(xclk_i), .rise_o(rise)
    );

    cc_reader #(.W(CH_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .req_i(rd_req_i), .hi_i(ch_cnt[1]), .lo_i(ch_cnt[0]),
        .valid_o(rd_valid_o), .data_o(rd_data_o)
    );

    assign count_o = {ch_cnt[1], ch_cnt[0]};
endmodule

// File: rtl/chained_counter_chk.sv
// Temporal checks on the chained counter, attached by bind.
module chained_counter_chk #(
    parameter int CH_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_i,
    input logic              lo_en_i,
    input logic [2*CH_W-1:0] count_o,
    input logic              lo_wave_o,
    input logic              rd_valid_o,
    input logic [2*CH_W-1:0] rd_data_o
);
    localparam logic [CH_W-1:0] ONE = CH_W'(1);
    localparam logic [CH_W-1:0] MID = CH_W'(1) << (CH_W - 1);

    logic [CH_W-1:0] lo_w;
    logic [CH_W-1:0] hi_w;
    assign lo_w = count_o[CH_W-1:0];
    assign hi_w = count_o[2*CH_W-1:CH_W];

    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (count_o == '0));                                        // R2
    AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> (lo_w == $past(lo_w) || lo_w == $past(lo_w) + ONE));    // R3
    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && !lo_en_i) |=> $stable(lo_w));                           // R3
    AST_WAVE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_wave_o) |-> (lo_w == '0));                                 // R4
    AST_WAVE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lo_wave_o) |-> (lo_w == MID || $past(sync_i)));               // R4
    AST_HI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> (hi_w == $past(hi_w) || hi_w == $past(hi_w) + ONE));    // R5
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);                                        // R9
    AST_RD_HI_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_data_o[2*CH_W-1:CH_W] == $past(hi_w)));          // R9
    AST_RD_LO_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_data_o[CH_W-1:0] == $past(lo_w, 2)));            // R9
endmodule

bind chained_counter chained_counter_chk #(.CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .lo_en_i(lo_en_i),
    .count_o(count_o), .lo_wave_o(lo_wave_o), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o)
);

// File: tb/chained_counter_test.sv
`timescale 1ns/1ps
module chained_counter_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n, sync_i, lo_en_i, hi_en_i, xclk_i, rd_req_i;
    logic [1:0]   psc_sel_i, route_i;
    logic [7:0]   count_o, rd_data_o;
    logic         lo_wave_o, rd_valid_o;

    int errors = 0;
    int checks = 0;
    int n = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chained_counter #(.CH_W(W), .SEL_W(2), .PSC_STEP(2)) uut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .psc_sel_i(psc_sel_i),
        .lo_en_i(lo_en_i), .hi_en_i(hi_en_i), .route_i(route_i), .xclk_i(xclk_i),
        .rd_req_i(rd_req_i), .count_o(count_o), .lo_wave_o(lo_wave_o),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at n=%0d: actual=0x%0h expected=0x%0h", req, n, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n++;
    endtask

    task automatic do_sync();
        sync_i = 1'b1;
        step();
        sync_i = 1'b0;
        n = 0;
    endtask

    function automatic int exp_cnt(input int nn, input int d);
        int lo, hi;
        lo = (nn / d) % 16;
        hi = (nn >= 1) ? (((nn - 1) / d) / 16) % 16 : 0;
        return hi * 16 + lo;
    endfunction

    function automatic bit exp_wave(input int nn, input int d);
        int t;
        t = nn / d;
        return (t >= 16) && ((t % 16) < 8);
    endfunction

    task automatic do_read(output int lat, output int data);
        int r;
        r = n;
        rd_req_i = 1'b1;
        step();
        rd_req_i = 1'b0;
        lat = -1;
        data = 0;
        for (int i = 0; i < 12 && lat < 0; i++) begin
            if (rd_valid_o) begin
                lat = n - r;
                data = int'(rd_data_o);
            end else step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lat, data, snap, d, nvalid;
        rst_n = 1'b0; sync_i = 1'b0; lo_en_i = 1'b0; hi_en_i = 1'b0;
        xclk_i = 1'b0; rd_req_i = 1'b0; psc_sel_i = 2'd0; route_i = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(count_o == 8'h00, "R1 count", int'(count_o), 0);
        chk(lo_wave_o == 1'b0, "R1 wave", int'(lo_wave_o), 0);
        chk(rd_valid_o == 1'b0, "R1 valid", int'(rd_valid_o), 0);
        rst_n = 1'b1;
        lo_en_i = 1'b1; hi_en_i = 1'b1;

        // R8 R4 sweep every divisor through more than one full wrap of the whole count
        for (int s = 0; s < 4; s++) begin
            psc_sel_i = 2'(s);
            d = 1 << (1 + 2 * s);
            step();
            do_sync();
            chk(count_o == 8'h00, "R2 after sync", int'(count_o), 0);
            for (int k = 0; k < d * 256 + d * 40; k++) begin
                step();
                chk(int'(count_o) == exp_cnt(n, d) % 256, "R8 count", int'(count_o), exp_cnt(n, d));
                chk(lo_wave_o == exp_wave(n, d), "R4 wave", int'(lo_wave_o), int'(exp_wave(n, d)));
            end
        end

        // R3 divisor 8 period edges
        psc_sel_i = 2'd1;
        do_sync();
        repeat (7) step();
        chk(count_o[3:0] == 4'd0, "R3 before tick", int'(count_o[3:0]), 0);
        step();
        chk(count_o[3:0] == 4'd1, "R3 first tick", int'(count_o[3:0]), 1);

        // R5 upper stage follows the wrap by one clock
        psc_sel_i = 2'd0;
        do_sync();
        repeat (32) step();
        chk(count_o == 8'h00, "R5 wrap cycle", int'(count_o), 8'h00);
        step();
        chk(count_o == 8'h10, "R5 after wrap", int'(count_o), 8'h10);

        // R3 hold with lower enable low
        do_sync();
        repeat (10) step();
        lo_en_i = 1'b0;
        step();
        snap = int'(count_o);
        repeat (40) step();
        chk(int'(count_o) == snap, "R3 hold", int'(count_o), snap);
        lo_en_i = 1'b1;

        // R7 upper enable low
        hi_en_i = 1'b0;
        do_sync();
        repeat (70) step();
        chk(count_o[7:4] == 4'd0, "R7 hi hold", int'(count_o[7:4]), 0);
        chk(int'(count_o[3:0]) == (n / 2) % 16, "R7 lo runs", int'(count_o[3:0]), (n / 2) % 16);
        hi_en_i = 1'b1;

        // R5 unrouted codes hold the upper stage
        for (int rc = 0; rc < 4; rc += 3) begin
            route_i = 2'(rc);
            do_sync();
            repeat (70) step();
            chk(count_o[7:4] == 4'd0, "R5 route off", int'(count_o[7:4]), 0);
        end

        // R6 outside source, one count per rising edge
        route_i = 2'b10;
        lo_en_i = 1'b0;
        do_sync();
        for (int i = 0; i < 5; i++) begin
            xclk_i = 1'b1;
            step();
            chk(int'(count_o[7:4]) == i + 1, "R6 rise", int'(count_o[7:4]), i + 1);
            step();
            chk(int'(count_o[7:4]) == i + 1, "R6 high level", int'(count_o[7:4]), i + 1);
            xclk_i = 1'b0;
            step();
        end
        chk(lo_wave_o == 1'b0, "R4 wave idle", int'(lo_wave_o), 0);

        // R2 mid-run restart
        route_i = 2'b01;
        lo_en_i = 1'b1;
        do_sync();
        repeat (100) step();
        do_sync();
        chk(count_o == 8'h00, "R2 restart", int'(count_o), 0);
        step(); step();
        chk(count_o == 8'h01, "R2 resumes", int'(count_o), 1);

        // R9 plain read, three clocks
        do_sync();
        repeat (20) step();
        do_read(lat, data);
        chk(lat == 3, "R9 latency", lat, 3);
        chk(data == exp_cnt(n - 2, 2) % 256, "R9 data", data, exp_cnt(n - 2, 2));

        // R9 read placed on a wrap, retried
        while (n < 63) step();
        do_read(lat, data);
        chk(lat == 5, "R9 retry latency", lat, 5);
        chk(data == 8'h21, "R9 retry data", data, 8'h21);

        // R10 second request while busy is dropped
        while (n < 100) step();
        rd_req_i = 1'b1;
        step(); step();
        rd_req_i = 1'b0;
        nvalid = 0;
        for (int i = 0; i < 12; i++) begin
            if (rd_valid_o) nvalid++;
            step();
        end
        chk(nvalid == 1, "R10 single result", nvalid, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule